// File: doc/BRIEF.md
# Configuration Window Base Decoder

This block keeps the 64-bit base register that a host bridge uses to place its memory-mapped configuration window, and turns the register contents into a ready-to-use window description: an enable flag, an aligned base address and the window size in bytes. From the same decode it also produces the lower and upper bounds of the 32-bit PCI memory hole. The hole starts just above an enabled window, or at the reset-default base when no window is active. It always ends one byte below the interrupt-controller area at 0xFEC00000.

Software or a configuration agent updates the register through a byte-enabled write port. Any write that touches at least one byte re-evaluates the decode, and the new window description appears one clock after the write is accepted. A small control machine holds the decode result in one of three states. `WIN_OFF` means the window is disabled. `WIN_ON` means the window is active. `WIN_FAULT` means the register holds the illegal length code. Reset places the machine in the state that the default register value decodes to. A write that touches the register moves the machine to the state decoded from the merged register value, which may also be the current state. Any other cycle holds the state.

The length field selects the window size. It also widens the base-address mask, so a smaller window can be placed on a finer alignment.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads 0x00000000_B0000000. The window is disabled, `win_base` and `win_len` are 0, `len_err` is 0, `hole_lo` is 0xB0000000 and `hole_hi` is 0xFEBFFFFF.
- R2: On an accepted write, byte i of the register (bits 8i+7:8i) takes byte i of `wr_data` when `wr_be[i]` is 1, and keeps its old value otherwise. `reg_q` always shows the register.
- R3: A cycle with `wr_en` low, or with `wr_be` all zero, changes neither the register nor any output.
- R4: When bit 0 (the enable bit) is 0 and the length code is legal, `win_en` is 0 and both `win_base` and `win_len` are 0.
- R5: The length code sits in bits 2:1. Code 0 gives `win_len` = 0x10000000 (256 MiB), code 1 gives 0x08000000 (128 MiB) and code 2 gives 0x04000000 (64 MiB).
- R6: When enabled, `win_base` keeps register bits 35:28 for code 0, bits 35:27 for code 1 and bits 35:26 for code 2. All lower bits are zero, and bits 63:36 are ignored.
- R7: Length code 3 is reserved. It sets `len_err` and keeps the window disabled, whatever the enable bit holds. `len_err` clears once a legal code is written.
- R8: `hole_hi` is always 0xFEBFFFFF. `hole_lo` is bits 31:0 of `win_base + win_len` when the window is enabled, and 0xB0000000 otherwise.
- R9: The outputs change on the first rising clock edge that accepts a write, and not before.
- R10: Each single write can move the decode between any two of the states `WIN_OFF`, `WIN_ON` and `WIN_FAULT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 8 | Byte enables, bit i for register byte i |
| wr_data | input | 64 | Write data |
| reg_q | output | 64 | Current register contents |
| win_en | output | 1 | Configuration window active |
| win_base | output | ADDR_W (36) | Aligned window base address |
| win_len | output | ADDR_W (36) | Window size in bytes |
| len_err | output | 1 | Reserved length code present |
| hole_lo | output | 32 | First byte of the 32-bit PCI hole |
| hole_hi | output | 32 | Last byte of the 32-bit PCI hole |

## Verification
The assertions assume that the write inputs carry known values whenever `wr_en` is high. They also assume that reset is held for at least one clock before the first write. The stimulus changes inputs only at falling edges and holds `wr_en` low between writes. Under these conditions every checked consequence of a write appears exactly one edge later. The stimulus programs enabled windows only at bases whose sum with the window size fits the checked range, so the 32-bit hole bound is taken from a sum that does not wrap. One vector deliberately sets bits above 35, to show that they are dropped.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    // Decode result held by the control machine
    typedef enum logic [1:0] {
        WIN_OFF   = 2'd0,
        WIN_ON    = 2'd1,
        WIN_FAULT = 2'd2
    } win_st_e;

    localparam int          LEN_CODE_W   = 2;
    localparam int          NUM_LEN_CODE = 3;      // legal size codes
    localparam logic [1:0]  LEN_RSVD     = 2'd3;   // illegal code
    localparam int          REG_BYTES    = 8;
    localparam int          REG_W        = REG_BYTES * 8;

endpackage

// File: rtl/cfgwin_bytereg.sv
module cfgwin_bytereg #(
    parameter int          NBYTES    = 8,
    parameter logic [63:0] RESET_VAL = 64'h0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [NBYTES-1:0]     wr_be,
    input  logic [NBYTES*8-1:0]   wr_data,
    output logic [NBYTES*8-1:0]   q,
    output logic [NBYTES*8-1:0]   merged,
    output logic                  hit
);
    localparam int W = NBYTES * 8;

    logic [W-1:0] rst_val;
    assign rst_val = RESET_VAL[W-1:0];

    assign hit = wr_en && (|wr_be);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Value the byte will hold after this edge
        assign merged[b*8 +: 8] = (wr_en && wr_be[b]) ? wr_data[b*8 +: 8]
                                                      : q[b*8 +: 8];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[b*8 +: 8] <= rst_val[b*8 +: 8];
            end else begin
                q[b*8 +: 8] <= merged[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/cfgwin_field_decode.sv
module cfgwin_field_decode
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W   = 36,
    parameter int MAX_LOG2 = 28,
    parameter int EN_BIT   = 0,
    parameter int LEN_LSB  = 1
) (
    input  logic [REG_W-1:0]  val,
    output win_st_e           st,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] len
);
    logic [ADDR_W-1:0] mask_tbl [NUM_LEN_CODE];
    logic [ADDR_W-1:0] size_tbl [NUM_LEN_CODE];

    // Code k halves the window k times and keeps k more base bits
    for (genvar k = 0; k < NUM_LEN_CODE; k++) begin : g_len
        assign mask_tbl[k] = {ADDR_W{1'b1}} << (MAX_LOG2 - k);
        assign size_tbl[k] = {{(ADDR_W-1){1'b0}}, 1'b1} << (MAX_LOG2 - k);
    end

    logic [LEN_CODE_W-1:0] code;
    logic                  enable;
    logic [ADDR_W-1:0]     raw_addr;
    logic                  unused_hi;

    assign code      = val[LEN_LSB +: LEN_CODE_W];
    assign enable    = val[EN_BIT];
    assign raw_addr  = val[ADDR_W-1:0];
    assign unused_hi = ^val[REG_W-1:ADDR_W];

    always_comb begin
        st   = WIN_OFF;
        base = '0;
        len  = '0;
        if (code == LEN_RSVD) begin
            st = WIN_FAULT;
        end else if (enable) begin
            st = WIN_ON;
            for (int k = 0; k < NUM_LEN_CODE; k++) begin
                if (code == LEN_CODE_W'(k)) begin
                    base = raw_addr & mask_tbl[k];
                    len  = size_tbl[k];
                end
            end
        end
    end

endmodule

// File: rtl/cfgwin_ctrl_fsm.sv
module cfgwin_ctrl_fsm
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W    = 36,
    parameter int          HOLE_W    = 32,
    parameter logic [31:0] APIC_BASE = 32'hFEC0_0000,
    parameter logic [31:0] DEF_HOLE  = 32'hB000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  win_st_e           nxt_st,
    input  logic [ADDR_W-1:0] nxt_base,
    input  logic [ADDR_W-1:0] nxt_len,
    input  win_st_e           rst_st,
    input  logic [ADDR_W-1:0] rst_base,
    input  logic [ADDR_W-1:0] rst_len,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] win_len,
    output logic              len_err,
    output logic [HOLE_W-1:0] hole_lo,
    output logic [HOLE_W-1:0] hole_hi
);
    win_st_e           state;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] len_q;
    logic [ADDR_W-1:0] win_end;

    // State register: reset loads the default decode, a write reloads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= rst_st;
            base_q <= rst_base;
            len_q  <= rst_len;
        end else if (hit) begin
            state  <= nxt_st;
            base_q <= nxt_base;
            len_q  <= nxt_len;
        end
    end

    assign win_end = base_q + len_q;
    assign hole_hi = HOLE_W'(APIC_BASE - 32'd1);

    // Output decode per state
    always_comb begin
        win_en   = 1'b0;
        win_base = '0;
        win_len  = '0;
        len_err  = 1'b0;
        hole_lo  = HOLE_W'(DEF_HOLE);
        unique case (state)
            WIN_ON: begin
                win_en   = 1'b1;
                win_base = base_q;
                win_len  = len_q;
                hole_lo  = win_end[HOLE_W-1:0];
            end
            WIN_FAULT: begin
                len_err = 1'b1;
            end
            WIN_OFF: begin
                hole_lo = HOLE_W'(DEF_HOLE);
            end
            default: begin
                hole_lo = HOLE_W'(DEF_HOLE);
            end
        endcase
    end

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int          ADDR_W       = 36,
    parameter int          MAX_LOG2     = 28,
    parameter int          EN_BIT       = 0,
    parameter int          LEN_LSB      = 1,
    parameter logic [63:0] DEFAULT_BASE = 64'h0000_0000_B000_0000,
    parameter logic [31:0] APIC_BASE    = 32'hFEC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_be,
    input  logic [63:0]       wr_data,
    output logic [63:0]       reg_q,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] win_len,
    output logic              len_err,
    output logic [31:0]       hole_lo,
    output logic [31:0]       hole_hi
);
    localparam logic [31:0] DEF_HOLE = DEFAULT_BASE[31:0] & ~32'h7;

    logic [63:0]       merged;
    logic              hit;
    win_st_e           nxt_st;
    logic [ADDR_W-1:0] nxt_base;
    logic [ADDR_W-1:0] nxt_len;
    win_st_e           rst_st;
    logic [ADDR_W-1:0] rst_base;
    logic [ADDR_W-1:0] rst_len;

    cfgwin_bytereg #(
        .NBYTES    (REG_BYTES),
        .RESET_VAL (DEFAULT_BASE)
    ) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .q       (reg_q),
        .merged  (merged),
        .hit     (hit)
    );

    cfgwin_field_decode #(
        .ADDR_W   (ADDR_W),
        .MAX_LOG2 (MAX_LOG2),
        .EN_BIT   (EN_BIT),
        .LEN_LSB  (LEN_LSB)
    ) dec_wr_i (
        .val  (merged),
        .st   (nxt_st),
        .base (nxt_base),
        .len  (nxt_len)
    );

    cfgwin_field_decode #(
        .ADDR_W   (ADDR_W),
        .MAX_LOG2 (MAX_LOG2),
        .EN_BIT   (EN_BIT),
        .LEN_LSB  (LEN_LSB)
    ) dec_rst_i (
        .val  (DEFAULT_BASE),
        .st   (rst_st),
        .base (rst_base),
        .len  (rst_len)
    );

    cfgwin_ctrl_fsm #(
        .ADDR_W    (ADDR_W),
        .HOLE_W    (32),
        .APIC_BASE (APIC_BASE),
        .DEF_HOLE  (DEF_HOLE)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .nxt_st   (nxt_st),
        .nxt_base (nxt_base),
        .nxt_len  (nxt_len),
        .rst_st   (rst_st),
        .rst_base (rst_base),
        .rst_len  (rst_len),
        .win_en   (win_en),
        .win_base (win_base),
        .win_len  (win_len),
        .len_err  (len_err),
        .hole_lo  (hole_lo),
        .hole_hi  (hole_hi)
    );

endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk #(
    parameter int          ADDR_W   = 36,
    parameter int          MAX_LOG2 = 28,
    parameter logic [31:0] DEF_HOLE = 32'hB000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_be,
    input logic [63:0]       wr_data,
    input logic [63:0]       reg_q,
    input logic              win_en,
    input logic [ADDR_W-1:0] win_base,
    input logic [ADDR_W-1:0] win_len,
    input logic              len_err,
    input logic [31:0]       hole_lo
);
    localparam logic [ADDR_W-1:0] MIN_LEN = ADDR_W'(1) << (MAX_LOG2 - 2);

    AST_BYTE0_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0]) |=> reg_q[7:0] == $past(wr_data[7:0])); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (|wr_be)) |=> ($stable(reg_q) && $stable(win_en)
                                  && $stable(win_base) && $stable(hole_lo))); // R3

    AST_EN_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0] && !wr_data[0]) |=> !win_en); // R4

    AST_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        win_en |-> ($countones(win_len) == 1 && win_len >= MIN_LEN)); // R5

    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        win_en |-> ((win_base & (win_len - ADDR_W'(1))) == '0)); // R6

    AST_RSVD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0] && wr_data[2:1] == 2'b11) |=> len_err); // R7

    AST_ERR_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> !win_en); // R7

    AST_HOLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |-> hole_lo == DEF_HOLE); // R8

endmodule

bind cfgwin_decoder cfgwin_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .MAX_LOG2 (MAX_LOG2),
    .DEF_HOLE (DEF_HOLE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .reg_q    (reg_q),
    .win_en   (win_en),
    .win_base (win_base),
    .win_len  (win_len),
    .len_err  (len_err),
    .hole_lo  (hole_lo)
);

// File: tb/cfgwin_decoder_tb_top.sv
`timescale 1ns/1ps
module cfgwin_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_be = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] reg_q;
    logic        win_en;
    logic [35:0] win_base;
    logic [35:0] win_len;
    logic        len_err;
    logic [31:0] hole_lo;
    logic [31:0] hole_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    cfgwin_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .reg_q(reg_q), .win_en(win_en),
        .win_base(win_base), .win_len(win_len), .len_err(len_err),
        .hole_lo(hole_lo), .hole_hi(hole_hi)
    );

    typedef struct packed {
        logic [63:0] data;
        logic        en;
        logic [35:0] base;
        logic [35:0] len;
        logic        err;
        logic [31:0] hole;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_E000_0001, 1'b1, 36'h0_E000_0000, 36'h0_1000_0000, 1'b0, 32'hF000_0000},
        '{64'h0000_0000_E800_0003, 1'b1, 36'h0_E800_0000, 36'h0_0800_0000, 1'b0, 32'hF000_0000},
        '{64'h0000_0000_E400_0005, 1'b1, 36'h0_E400_0000, 36'h0_0400_0000, 1'b0, 32'hE800_0000},
        '{64'h0000_0000_E400_0003, 1'b1, 36'h0_E000_0000, 36'h0_0800_0000, 1'b0, 32'hE800_0000},
        '{64'h0000_0000_EC00_0001, 1'b1, 36'h0_E000_0000, 36'h0_1000_0000, 1'b0, 32'hF000_0000},
        '{64'h0000_0000_E000_0007, 1'b0, 36'h0,           36'h0,           1'b1, 32'hB000_0000},
        '{64'h0000_0000_E000_0006, 1'b0, 36'h0,           36'h0,           1'b1, 32'hB000_0000},
        '{64'h0000_0000_E000_0000, 1'b0, 36'h0,           36'h0,           1'b0, 32'hB000_0000},
        '{64'h0000_00F1_D000_0001, 1'b1, 36'h1_D000_0000, 36'h0_1000_0000, 1'b0, 32'hE000_0000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] be, input logic [63:0] d, input logic en);
        @(negedge clk);
        wr_en   = en;
        wr_be   = be;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        wr_be = '0;
    endtask

    task automatic check_out(input string tag, input logic e, input logic [35:0] b,
                             input logic [35:0] l, input logic er, input logic [31:0] h);
        chk({tag, " R4 en"},      64'(win_en),   64'(e));
        chk({tag, " R6 base"},    64'(win_base), 64'(b));
        chk({tag, " R5 len"},     64'(win_len),  64'(l));
        chk({tag, " R7 R10 err"}, 64'(len_err),  64'(er));
        chk({tag, " R8 hole_lo"}, 64'(hole_lo),  64'(h));
        chk({tag, " R8 hole_hi"}, 64'(hole_hi),  64'h0000_0000_FEBF_FFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reg", reg_q, 64'h0000_0000_B000_0000);
        check_out("R1", 1'b0, 36'h0, 36'h0, 1'b0, 32'hB000_0000);

        // Table walk: sizes, masks, reserved code, disable, upper bits
        for (int i = 0; i < NV; i++) begin
            write(8'hFF, VECS[i].data, 1'b1);
            chk($sformatf("R2 vec%0d reg", i), reg_q, VECS[i].data);
            check_out($sformatf("vec%0d", i), VECS[i].en, VECS[i].base,
                      VECS[i].len, VECS[i].err, VECS[i].hole);
        end

        // R3: zero byte enables ignored
        write(8'h00, 64'h0, 1'b1);
        chk("R3 be0 reg", reg_q, 64'h0000_00F1_D000_0001);
        check_out("R3 be0", 1'b1, 36'h1_D000_0000, 36'h0_1000_0000, 1'b0, 32'hE000_0000);

        // R3: strobe low ignored
        write(8'hFF, 64'h0, 1'b0);
        chk("R3 noen reg", reg_q, 64'h0000_00F1_D000_0001);
        check_out("R3 noen", 1'b1, 36'h1_D000_0000, 36'h0_1000_0000, 1'b0, 32'hE000_0000);

        // R2: byte 0 only -> 64 MiB
        write(8'h01, 64'hFFFF_FFFF_FFFF_FF05, 1'b1);
        chk("R2 b0 reg", reg_q, 64'h0000_00F1_D000_0005);
        check_out("R2 b0", 1'b1, 36'h1_D000_0000, 36'h0_0400_0000, 1'b0, 32'hD400_0000);

        // R2: byte 3 only
        write(8'h08, 64'h0000_0000_E000_0000, 1'b1);
        chk("R2 b3 reg", reg_q, 64'h0000_00F1_E000_0005);
        check_out("R2 b3", 1'b1, 36'h1_E000_0000, 36'h0_0400_0000, 1'b0, 32'hE400_0000);

        // R9: no change before the accepting edge
        @(negedge clk);
        wr_en = 1'b1; wr_be = 8'hFF; wr_data = 64'h0;
        #1;
        chk("R9 before edge en", 64'(win_en), 64'h1);
        @(posedge clk);
        #1;
        wr_en = 1'b0; wr_be = '0;
        chk("R9 after edge en", 64'(win_en), 64'h0);
        chk("R9 after edge hole", 64'(hole_lo), 64'hB000_0000);

        // R10: fault straight to on
        write(8'hFF, 64'h0000_0000_E000_0007, 1'b1);
        write(8'hFF, 64'h0000_0000_C000_0005, 1'b1);
        check_out("R10 fault->on", 1'b1, 36'h0_C000_0000, 36'h0_0400_0000, 1'b0, 32'hC400_0000);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1 rerun reg", reg_q, 64'h0000_0000_B000_0000);
        check_out("R1 rerun", 1'b0, 36'h0, 36'h0, 1'b0, 32'hB000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule